// File: doc/BRIEF.md
# Replay Trace Divergence Comparator

This block supports fault diagnosis by re-running one thread in isolation. In a capture window it watches retiring instructions and stores every branch, load and store event in a trace buffer. Each entry keeps the event kind, its address or branch target, and its data: the value a load returned, the value a store wrote, or a branch's taken bit. Other instructions are only counted. Because load results are kept, the thread can be replayed later on another core without any log of memory ordering.

In a replay window the block hands the recorded load values back to the core, oldest first. It checks each replayed branch, load and store against the next recorded entry. On the first mismatch it stops and holds the zero-based instruction index and the kind of the offending event. If every entry matches by the end of the window, it reports a clean match. Windows are a fixed number of instructions long, so that diagnosis can be repeated over short slices. A capture that fills the buffer ends its window early and reports this with a status of its own.

Top module: `replay_trace_cmp`

## Requirements
- R1: After reset, `mode` is idle (0), `status` is none (0), `div_index` and `div_kind` are 0, and `rp_ld_valid` is low.
- R2: A `cmd_capture` pulse in idle or done mode enters capture mode (1), and a `cmd_replay` pulse enters replay mode (2). Either one clears `status`, `div_index` and `div_kind`, with capture winning if both are set. Commands are ignored while in capture or replay mode.
- R3: In capture mode, each valid event of kind branch (1), load (2) or store (3) is stored in retire order. Kind 0 (other) only advances the instruction count. For a branch only bit 0 of `ev_data` is kept. The cycle after `WINDOW_LEN` instructions have retired, the block enters done mode (3) with status captured (1), and the replay window length becomes `WINDOW_LEN`.
- R4: If a branch, load or store arrives in capture mode while `DEPTH` entries are already stored, the block enters done mode with status overflow (2). That instruction is neither stored nor counted, and the replay window length becomes the number of instructions retired before it.
- R5: In replay mode, while the next unconsumed entry is a load, `rp_ld_valid` is high and `rp_ld_data` holds that entry's recorded value. Otherwise `rp_ld_valid` is low.
- R6: The cycle after a replay has retired as many instructions as the replay window length, the block enters done mode. If every stored entry was consumed it reports status match (3).
- R7: A replayed branch, load or store mismatches when its kind or address differs from the next entry, when a branch's taken bit differs, or when a store's data differs. The data of a replayed load is not compared. On a mismatch the block enters done mode with status diverge (4), `div_index` set to the instruction's zero-based index in the window, and `div_kind` set to the replayed kind.
- R8: A replayed branch, load or store that arrives after all entries are consumed is a divergence with its kind. A replay window that ends with entries still unconsumed reports diverge, with `div_index` equal to the window length and `div_kind` 0.
- R9: Events in idle or done mode change no stored entry: a later replay of the same sequence still reports match.
- R10: The same capture can be replayed any number of times, each replay starting from the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_capture | input | 1 | Start a capture window |
| cmd_replay | input | 1 | Start a replay window |
| ev_valid | input | 1 | One instruction retires this cycle |
| ev_kind | input | 2 | 0 other, 1 branch, 2 load, 3 store |
| ev_addr | input | ADDR_W | Load/store address or branch target |
| ev_data | input | DATA_W | Load value, store data, or taken bit in bit 0 |
| rp_ld_valid | output | 1 | A recorded load value is offered |
| rp_ld_data | output | DATA_W | Recorded load value for the replayed load |
| mode | output | 2 | 0 idle, 1 capture, 2 replay, 3 done |
| status | output | 3 | 0 none, 1 captured, 2 overflow, 3 match, 4 diverge |
| div_index | output | IDX_W | Instruction index of the divergence |
| div_kind | output | 2 | Kind of the diverging replayed event |

## Verification
Replay is driven first with a sequence identical to the capture, which separates a clean match from false alarms. Then a single field is disturbed at a time: store data, branch taken bit, load address, a recordable event dropped, or one added. This tells the compared fields apart from the ignored load data, and a mismatch inside the window from entries left over at its end. One capture fills the buffer exactly, without overflow, and another overruns it. Replaying the overrun capture shows that the shortened window is used. Commands issued mid-window and events sent while done show that neither disturbs state.

// File: rtl/rtc_pkg.sv
// Shared encodings for the replay trace comparator.
// Assumes: kind, mode and status codes are visible at the top ports.
package rtc_pkg;
    typedef enum logic [1:0] {K_OTHER = 2'd0, K_BRANCH = 2'd1, K_LOAD = 2'd2, K_STORE = 2'd3} kind_e;
    typedef enum logic [1:0] {M_IDLE = 2'd0, M_CAPTURE = 2'd1, M_REPLAY = 2'd2, M_DONE = 2'd3} mode_e;
    typedef enum logic [2:0] {S_NONE = 3'd0, S_CAPTURED = 3'd1, S_OVERFLOW = 3'd2,
                              S_MATCH = 3'd3, S_DIVERGE = 3'd4} stat_e;
endpackage

// File: rtl/rtc_trace_buf.sv
// Trace storage: entries are appended at a write pointer during capture
// and consumed in the same order through a read pointer during replay.
// Assumes: the controller never writes when full nor reads when empty.
module rtc_trace_buf #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_wr,
    input  logic              clr_rd,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic              full,
    output logic              avail,
    output logic [1:0]        hd_kind,
    output logic [ADDR_W-1:0] hd_addr,
    output logic [DATA_W-1:0] hd_data
);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [1:0]        kind_mem [DEPTH];
    logic [ADDR_W-1:0] addr_mem [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    assign full  = (wr_ptr == PTR_W'(DEPTH));
    assign avail = (rd_ptr < wr_ptr);

    // Store an entry at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            kind_mem[wr_ptr[SEL_W-1:0]] <= wr_kind;
            addr_mem[wr_ptr[SEL_W-1:0]] <= wr_addr;
            data_mem[wr_ptr[SEL_W-1:0]] <= wr_data;
        end
    end

    // Advance or clear the two pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (clr_wr)     wr_ptr <= '0;
            else if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (clr_rd)     rd_ptr <= '0;
            else if (rd_en) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Present the oldest unconsumed entry, zero when none is left.
    always_comb begin
        hd_kind = '0;
        hd_addr = '0;
        hd_data = '0;
        if (avail) begin
            hd_kind = kind_mem[rd_ptr[SEL_W-1:0]];
            hd_addr = addr_mem[rd_ptr[SEL_W-1:0]];
            hd_data = data_mem[rd_ptr[SEL_W-1:0]];
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    assert_read_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> avail);
    assert_rd_behind_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= wr_ptr);
endmodule

// File: rtl/rtc_event_cmp.sv
// Compares one replayed event with the next recorded entry.
// Assumes: branch entries keep only the taken bit in data bit 0.
module rtc_event_cmp #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input  logic              avail,
    input  logic [1:0]        hd_kind,
    input  logic [ADDR_W-1:0] hd_addr,
    input  logic [DATA_W-1:0] hd_data,
    input  logic [1:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    output logic              miss
);
    import rtc_pkg::*;

    // Kind and address always count; data counts for branch and store only.
    always_comb begin
        miss = !avail || (hd_kind != ev_kind) || (hd_addr != ev_addr);
        if (ev_kind == K_BRANCH && hd_data[0] != ev_data[0]) miss = 1'b1;
        if (ev_kind == K_STORE  && hd_data != ev_data)       miss = 1'b1;
    end
endmodule

// File: rtl/rtc_ctrl.sv
// Window controller: holds the mode, counts retired instructions,
// decides window end, overflow and divergence, and steers the buffer.
// Assumes: at most one instruction retires per cycle.
module rtc_ctrl #(
    parameter int WINDOW_LEN = 100000,
    parameter int IDX_W      = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_capture,
    input  logic             cmd_replay,
    input  logic             ev_valid,
    input  logic [1:0]       ev_kind,
    input  logic             full,
    input  logic             avail,
    input  logic             miss,
    output logic [1:0]       mode,
    output logic [2:0]       status,
    output logic [IDX_W-1:0] div_index,
    output logic [1:0]       div_kind,
    output logic             wr_en,
    output logic             rd_en,
    output logic             clr_wr,
    output logic             clr_rd
);
    import rtc_pkg::*;

    mode_e            mode_q;
    stat_e            stat_q;
    logic [IDX_W-1:0] idx_q, cap_len_q;
    logic             rec, startable, cap_end, rp_end;

    assign mode   = mode_q;
    assign status = stat_q;

    // Decode the event and the end of window conditions.
    always_comb begin
        rec       = ev_valid && (ev_kind != K_OTHER);
        startable = (mode_q == M_IDLE) || (mode_q == M_DONE);
        cap_end   = (mode_q == M_CAPTURE) && (idx_q == IDX_W'(WINDOW_LEN));
        rp_end    = (mode_q == M_REPLAY) && (idx_q == cap_len_q);
        wr_en     = (mode_q == M_CAPTURE) && !cap_end && rec && !full;
        rd_en     = (mode_q == M_REPLAY) && !rp_end && rec && !miss;
        clr_wr    = startable && cmd_capture;
        clr_rd    = startable && (cmd_capture || cmd_replay);
    end

    // Mode, counter and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= M_IDLE;
            stat_q    <= S_NONE;
            idx_q     <= '0;
            cap_len_q <= '0;
            div_index <= '0;
            div_kind  <= '0;
        end else begin
            case (mode_q)
                M_IDLE, M_DONE: begin
                    if (cmd_capture || cmd_replay) begin
                        mode_q    <= cmd_capture ? M_CAPTURE : M_REPLAY;
                        stat_q    <= S_NONE;
                        idx_q     <= '0;
                        div_index <= '0;
                        div_kind  <= '0;
                    end
                end
                M_CAPTURE: begin
                    if (cap_end) begin
                        mode_q    <= M_DONE;
                        stat_q    <= S_CAPTURED;
                        cap_len_q <= idx_q;
                    end else if (ev_valid) begin
                        if (rec && full) begin
                            mode_q    <= M_DONE;
                            stat_q    <= S_OVERFLOW;
                            cap_len_q <= idx_q;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (rp_end) begin
                        mode_q <= M_DONE;
                        if (avail) begin
                            stat_q    <= S_DIVERGE;
                            div_index <= idx_q;
                        end else begin
                            stat_q <= S_MATCH;
                        end
                    end else if (ev_valid) begin
                        if (rec && miss) begin
                            mode_q    <= M_DONE;
                            stat_q    <= S_DIVERGE;
                            div_index <= idx_q;
                            div_kind  <= ev_kind;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assert_replay_within_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_REPLAY) |-> (idx_q <= cap_len_q));
    assert_capture_within_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_CAPTURE) |-> (idx_q <= IDX_W'(WINDOW_LEN)));
    assert_diverge_only_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == S_DIVERGE) |-> (mode_q == M_DONE));
    assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_DONE && $past(mode_q == M_DONE)) |-> ($stable(div_index) && $stable(div_kind)));
    assert_cmd_ignored_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_REPLAY && !rp_end && !ev_valid) |=> (mode_q == M_REPLAY));
endmodule

// File: rtl/replay_trace_cmp.sv
// Top level: ties trace buffer, event comparator and window controller
// together and offers recorded load values during replay.
// Assumes: ev_* is sampled only when ev_valid is high.
module replay_trace_cmp #(
    parameter int DEPTH      = 16,
    parameter int ADDR_W     = 64,
    parameter int DATA_W     = 64,
    parameter int WINDOW_LEN = 100000,
    parameter int IDX_W      = $clog2(WINDOW_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_capture,
    input  logic              cmd_replay,
    input  logic              ev_valid,
    input  logic [1:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    output logic              rp_ld_valid,
    output logic [DATA_W-1:0] rp_ld_data,
    output logic [1:0]        mode,
    output logic [2:0]        status,
    output logic [IDX_W-1:0]  div_index,
    output logic [1:0]        div_kind
);
    import rtc_pkg::*;

    logic              wr_en, rd_en, clr_wr, clr_rd, full, avail, miss;
    logic [1:0]        hd_kind;
    logic [ADDR_W-1:0] hd_addr;
    logic [DATA_W-1:0] hd_data, wr_data;

    // Branches keep only the taken bit.
    always_comb begin
        wr_data = (ev_kind == K_BRANCH) ? {{(DATA_W-1){1'b0}}, ev_data[0]} : ev_data;
    end

    rtc_trace_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr_wr(clr_wr), .clr_rd(clr_rd),
        .wr_en(wr_en), .wr_kind(ev_kind), .wr_addr(ev_addr), .wr_data(wr_data),
        .rd_en(rd_en), .full(full), .avail(avail),
        .hd_kind(hd_kind), .hd_addr(hd_addr), .hd_data(hd_data)
    );

    rtc_event_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .avail(avail), .hd_kind(hd_kind), .hd_addr(hd_addr), .hd_data(hd_data),
        .ev_kind(ev_kind), .ev_addr(ev_addr), .ev_data(ev_data), .miss(miss)
    );

    rtc_ctrl #(.WINDOW_LEN(WINDOW_LEN), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_capture(cmd_capture), .cmd_replay(cmd_replay),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .full(full), .avail(avail), .miss(miss),
        .mode(mode), .status(status), .div_index(div_index), .div_kind(div_kind),
        .wr_en(wr_en), .rd_en(rd_en), .clr_wr(clr_wr), .clr_rd(clr_rd)
    );

    // Offer the next recorded load value while replaying.
    always_comb begin
        rp_ld_valid = (mode == M_REPLAY) && avail && (hd_kind == K_LOAD);
        rp_ld_data  = rp_ld_valid ? hd_data : '0;
    end

    assert_ld_offer_only_replay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rp_ld_valid |-> (mode == M_REPLAY));
endmodule

// File: tb/replay_trace_cmp_bench.sv
// Bench: behavioural reference model (queues, integers) compared every cycle.
module replay_trace_cmp_bench;
    localparam int WL  = 12;
    localparam int DEP = 4;
    localparam int IW  = $clog2(WL + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_capture = 0, cmd_replay = 0, ev_valid = 0;
    logic [1:0]  ev_kind = 0;
    logic [63:0] ev_addr = 0, ev_data = 0;
    logic        rp_ld_valid;
    logic [63:0] rp_ld_data;
    logic [1:0]  mode, div_kind;
    logic [2:0]  status;
    logic [IW-1:0] div_index;

    always #2 clk = ~clk;

    replay_trace_cmp #(.DEPTH(DEP), .ADDR_W(64), .DATA_W(64), .WINDOW_LEN(WL)) u_replay_trace_cmp (
        .clk(clk), .rst_n(rst_n), .cmd_capture(cmd_capture), .cmd_replay(cmd_replay),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_addr(ev_addr), .ev_data(ev_data),
        .rp_ld_valid(rp_ld_valid), .rp_ld_data(rp_ld_data), .mode(mode), .status(status),
        .div_index(div_index), .div_kind(div_kind)
    );

    int n_chk = 0, n_fail = 0;
    // reference model state
    int m_mode = 0, m_stat = 0, m_idx = 0, m_cap = 0, m_rd = 0, m_dix = 0, m_dk = 0;
    int q_k[$];
    logic [63:0] q_a[$], q_d[$];
    // base sequence
    int s_k[WL];
    logic [63:0] s_a[WL], s_d[WL];

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model(bit cc, bit cr, bit v, int k, logic [63:0] a, logic [63:0] d);
        bit rec = v && (k != 0);
        bit mis;
        case (m_mode)
            0, 3: if (cc || cr) begin
                m_mode = cc ? 1 : 2; m_stat = 0; m_idx = 0; m_dix = 0; m_dk = 0; m_rd = 0;
                if (cc) begin q_k.delete(); q_a.delete(); q_d.delete(); end
            end
            1: if (m_idx == WL) begin m_mode = 3; m_stat = 1; m_cap = m_idx; end
               else if (v) begin
                   if (rec && q_k.size() == DEP) begin m_mode = 3; m_stat = 2; m_cap = m_idx; end
                   else begin
                       if (rec) begin q_k.push_back(k); q_a.push_back(a); q_d.push_back(k == 1 ? {63'b0, d[0]} : d); end
                       m_idx++;
                   end
               end
            default: if (m_idx == m_cap) begin
                   m_mode = 3;
                   if (m_rd < q_k.size()) begin m_stat = 4; m_dix = m_idx; end else m_stat = 3;
               end else if (v) begin
                   mis = 0;
                   if (rec) begin
                       if (m_rd >= q_k.size()) mis = 1;
                       else if (q_k[m_rd] != k || q_a[m_rd] != a) mis = 1;
                       else if (k == 1 && q_d[m_rd][0] != d[0]) mis = 1;
                       else if (k == 3 && q_d[m_rd] != d) mis = 1;
                   end
                   if (mis) begin m_mode = 3; m_stat = 4; m_dix = m_idx; m_dk = k; end
                   else begin if (rec) m_rd++; m_idx++; end
               end
        endcase
    endtask

    task automatic compare(string tag);
        bit lv = (m_mode == 2) && (m_rd < q_k.size()) && (q_k[m_rd] == 2);
        chk(mode == 2'(m_mode), tag, "mode", mode, m_mode);
        chk(status == 3'(m_stat), tag, "status", status, m_stat);
        chk(div_index == IW'(m_dix), tag, "div_index", div_index, m_dix);
        chk(div_kind == 2'(m_dk), tag, "div_kind", div_kind, m_dk);
        chk(rp_ld_valid == lv, {tag, "/R5"}, "rp_ld_valid", rp_ld_valid, lv);
        if (lv) chk(rp_ld_data == q_d[m_rd], {tag, "/R5"}, "rp_ld_data", rp_ld_data, q_d[m_rd]);
    endtask

    task automatic step(bit cc, bit cr, bit v, int k, logic [63:0] a, logic [63:0] d, string tag);
        cmd_capture = cc; cmd_replay = cr; ev_valid = v; ev_kind = 2'(k); ev_addr = a; ev_data = d;
        @(posedge clk); #1;
        model(cc, cr, v, k, a, d);
        compare(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
    endtask

    // Capture the base sequence, optionally with one extra store at index xi.
    task automatic capture(int xi, string tag);
        step(1, 0, 0, 0, 0, 0, {tag, "/R2"});
        for (int i = 0; i < WL; i++) begin
            if (i == xi) step(0, 0, 1, 3, 64'h900, 64'h77, tag);
            else step(0, 0, 1, s_k[i], s_a[i], s_d[i], tag);
            if (i == 3) idle(1, tag);
        end
        idle(3, tag);
    endtask

    // Replay the base sequence with one change at index mi:
    // 1 flip data bit 0, 2 flip address bit 3, 3 make other, 4 make store.
    task automatic replay(int len, int mi, int how, int busy_cmd_at, string tag);
        step(0, 1, 0, 0, 0, 0, {tag, "/R2"});
        for (int i = 0; i < len; i++) begin
            int k = s_k[i];
            logic [63:0] a = s_a[i], d = s_d[i];
            if (i == mi) begin
                if (how == 1) d = d ^ 64'h1;
                if (how == 2) a = a ^ 64'h8;
                if (how == 3) k = 0;
                if (how == 4) begin k = 3; a = 64'h500; end
            end
            step(i == busy_cmd_at, 0, 1, k, a, d, tag);
            if (i == 5) idle(1, tag);
        end
        idle(3, tag);
    endtask

    initial begin
        for (int i = 0; i < WL; i++) begin s_k[i] = 0; s_a[i] = 64'(i); s_d[i] = 0; end
        s_k[0] = 2; s_a[0] = 64'h100; s_d[0] = 64'hAAAA_0000_1111;
        s_k[2] = 1; s_a[2] = 64'h200; s_d[2] = 64'h1;
        s_k[4] = 3; s_a[4] = 64'h300; s_d[4] = 64'h5555;
        s_k[7] = 2; s_a[7] = 64'h108; s_d[7] = 64'hBBBB;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        compare("R1");
        capture(-1, "R3");                 // exactly DEPTH entries, no overflow
        step(0, 0, 1, 3, 64'h300, 64'h1, "R9"); // events in done are ignored
        step(0, 0, 1, 2, 64'h100, 64'h2, "R9");
        replay(WL, -1, 0, -1, "R6");       // identical replay matches
        replay(WL, -1, 0, -1, "R10");      // second replay of same capture
        replay(WL, 0, 1, -1, "R7");        // load data differs: ignored
        replay(WL, 4, 1, -1, "R7");        // store data differs
        replay(WL, 2, 1, -1, "R7");        // branch taken bit differs
        replay(WL, 7, 2, 3, "R7");         // load address differs, capture cmd mid-window ignored (R2)
        replay(WL, 7, 3, -1, "R8");        // recorded load never replayed
        replay(WL, 9, 4, -1, "R8");        // extra store after all consumed
        capture(9, "R4");                  // fifth recordable event overflows
        replay(9, -1, 0, -1, "R4");        // shortened window matches
        replay(WL, -1, 0, -1, "R4");       // extra instructions past window are ignored
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog timeout actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule